// File: doc/BRIEF.md
# Ingress Address Window Translator

This block sits on the receive side of a transaction interface and decides where each incoming read or write request goes. It holds a small table of programmable windows. Each window has a page-aligned bus base address, a page-multiple length, a source link (MAC) index, a local target base, an address-space tag and an ordering policy. A request that falls inside an enabled window from the same source link is forwarded one cycle later. Its address becomes the target base plus the request's offset inside the window, and it carries the window's address-space tag for later page translation. A request that falls in no window is consumed and flagged as a miss.

Each window counts the writes it has forwarded that have not yet completed. A completion pulse naming the window lowers the count. The window's ordering policy uses this count to decide whether a request may pass now or must be held with `req_ready` low. Three policies exist. Under the unordered policy only reads wait for earlier writes. Under the strict policy every request waits. Under the obey-packet policy, writes wait unless they carry the relaxed-ordering attribute. Software loads a whole window with a single write on the configuration port. A write that would leave a window misaligned or empty is refused and sets a sticky error flag.

Top module: `ingress_window_xlate`

## Requirements
- R1: After reset every window is disabled, all write counts are zero, `cfg_err`, `out_valid` and `out_miss` are low, and `req_ready` is high.
- R2: A request matches window i when window i is enabled, its MAC index equals `req_mac`, and base <= `req_addr` < base + length. When several windows match, the lowest-numbered one is used.
- R3: On the clock edge that accepts a matching request (`req_valid` and `req_ready` high), the block registers the following outputs, which are visible after that edge for one cycle: `out_valid`=1, `out_addr` = target + (`req_addr` - base), and the window's `out_asid`, `out_win` and `out_write`.
- R4: A request that matches no window is accepted at once with `req_ready` high. After the accepting edge, `out_miss`=1 and `out_valid`=0 for one cycle. `out_valid` and `out_miss` are never high together.
- R5: A configuration write with `cfg_en`=1 is refused when bits [11:0] of `cfg_base` or of `cfg_len` are non-zero, or when `cfg_len` is zero. A refused write leaves the window unchanged and sets `cfg_err`, which stays high until reset.
- R6: Ordering code 0 (unordered): a write to the window is never held for ordering. A read is held while the window's write count is non-zero.
- R7: Ordering code 1 (strict), and code 3 likewise: both reads and writes are held while the window's write count is non-zero.
- R8: Ordering code 2 (obey-packet): reads, and writes with `req_relaxed`=0, are held while the count is non-zero. A write with `req_relaxed`=1 is not held.
- R9: Each window's count rises by one on every accepted write that hits it. The count falls by one on a `wc_valid` pulse whose `wc_win` names that window. A completion pulse for a window whose count is zero is ignored. A write to a window whose count is at its maximum (15 by default) is held.
- R10: A configuration write with `cfg_en`=0 is always accepted and disables the window. A disabled window matches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Window being written |
| cfg_en | input | 1 | Enable for the written window |
| cfg_mac | input | 2 | Source MAC index the window serves |
| cfg_base | input | 32 | Bus base address of the window |
| cfg_len | input | 32 | Window length in bytes |
| cfg_tgt | input | 32 | Local target base address |
| cfg_order | input | 2 | Ordering code: 0 unordered, 1 strict, 2 obey-packet, 3 strict |
| cfg_asid | input | 4 | Address-space tag for the window |
| cfg_err | output | 1 | Sticky error: a configuration write was refused |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be taken this cycle |
| req_addr | input | 32 | Request bus address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_relaxed | input | 1 | Relaxed-ordering attribute |
| req_mac | input | 2 | Source MAC index of the request |
| wc_valid | input | 1 | Write-completion pulse |
| wc_win | input | 3 | Window whose write completed |
| out_valid | output | 1 | Translated request valid |
| out_miss | output | 1 | Accepted request matched no window |
| out_addr | output | 32 | Translated local address |
| out_asid | output | 4 | Address-space tag of the matched window |
| out_win | output | 3 | Index of the matched window |
| out_write | output | 1 | Direction of the translated request |

## Verification
The address sweep covers the first and last byte of each window, the bytes just outside each window, and an overlap between windows. In that sweep, an off-by-one bound would translate a byte that should miss, or a wrong priority would pick the higher window. The ordering tests show the exact request at which each policy starts and stops holding: a relaxed write passing a busy obey-packet window, and a read held behind writes in an unordered window. A policy decode that was swapped or wrong would let one of these through or hold it. Two counter cases are also covered. A completion pulse sent while the count is zero must not wrap the count, or a later read would pass too early. The count must stall exactly at its maximum, or it would wrap silently. The configuration tests confirm that a refused write leaves the old window working and that the error flag stays set.

// File: rtl/ingress_window_xlate.sv
module ingress_window_xlate #(
  parameter int NWIN  = 8,
  parameter int AW    = 32,
  parameter int MACW  = 2,
  parameter int ASIDW = 4,
  parameter int CW    = 4,
  parameter int PGB   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [$clog2(NWIN)-1:0] cfg_idx,
  input  logic                    cfg_en,
  input  logic [MACW-1:0]         cfg_mac,
  input  logic [AW-1:0]           cfg_base,
  input  logic [AW-1:0]           cfg_len,
  input  logic [AW-1:0]           cfg_tgt,
  input  logic [1:0]              cfg_order,
  input  logic [ASIDW-1:0]        cfg_asid,
  output logic                    cfg_err,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW-1:0]           req_addr,
  input  logic                    req_write,
  input  logic                    req_relaxed,
  input  logic [MACW-1:0]         req_mac,
  input  logic                    wc_valid,
  input  logic [$clog2(NWIN)-1:0] wc_win,
  output logic                    out_valid,
  output logic                    out_miss,
  output logic [AW-1:0]           out_addr,
  output logic [ASIDW-1:0]        out_asid,
  output logic [$clog2(NWIN)-1:0] out_win,
  output logic                    out_write
);
  localparam int IW = $clog2(NWIN);
  localparam logic [1:0] ORD_UNORD = 2'd0;
  localparam logic [1:0] ORD_OBEY  = 2'd2;

  logic [NWIN-1:0]             w_en;
  logic [NWIN-1:0][MACW-1:0]   w_mac;
  logic [NWIN-1:0][AW-1:0]     w_base, w_len, w_tgt;
  logic [NWIN-1:0][1:0]        w_ord;
  logic [NWIN-1:0][ASIDW-1:0]  w_asid;
  logic [NWIN-1:0][CW-1:0]     cnt;
  logic [NWIN-1:0]             hitv;

  logic          hit, busy, full, must_wait, accept, cfg_bad;
  logic [IW-1:0] sel;

  assign cfg_bad = cfg_en && ((|cfg_base[PGB-1:0]) || (|cfg_len[PGB-1:0]) || cfg_len == '0);

  genvar gi;
  generate
    for (gi = 0; gi < NWIN; gi++) begin : g_win
      logic [AW-1:0] off;
      logic          inc, dec;
      assign off = req_addr - w_base[gi];
      assign hitv[gi] = w_en[gi] && (w_mac[gi] == req_mac) &&
                        (req_addr >= w_base[gi]) && (off < w_len[gi]);
      assign inc = accept && hit && req_write && (sel == IW'(gi));
      assign dec = wc_valid && (wc_win == IW'(gi)) && (cnt[gi] != '0);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          w_en[gi]   <= 1'b0;
          w_mac[gi]  <= '0;
          w_base[gi] <= '0;
          w_len[gi]  <= '0;
          w_tgt[gi]  <= '0;
          w_ord[gi]  <= '0;
          w_asid[gi] <= '0;
          cnt[gi]    <= '0;
        end else begin
          if (cfg_we && cfg_idx == IW'(gi) && !cfg_bad) begin
            w_en[gi]   <= cfg_en;
            w_mac[gi]  <= cfg_mac;
            w_base[gi] <= cfg_base;
            w_len[gi]  <= cfg_len;
            w_tgt[gi]  <= cfg_tgt;
            w_ord[gi]  <= cfg_order;
            w_asid[gi] <= cfg_asid;
          end
          if (inc && !dec)      cnt[gi] <= cnt[gi] + 1'b1;
          else if (dec && !inc) cnt[gi] <= cnt[gi] - 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hitv[i]) begin
        hit = 1'b1;
        sel = IW'(i);
      end
    end
  end

  assign busy = cnt[sel] != '0;
  assign full = &cnt[sel];

  always_comb begin
    case (w_ord[sel])
      ORD_UNORD: must_wait = busy && !req_write;
      ORD_OBEY:  must_wait = busy && !(req_write && req_relaxed);
      default:   must_wait = busy;
    endcase
    if (req_write && full) must_wait = 1'b1;
  end

  assign req_ready = !(hit && must_wait);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_err   <= 1'b0;
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
      out_addr  <= '0;
      out_asid  <= '0;
      out_win   <= '0;
      out_write <= 1'b0;
    end else begin
      if (cfg_we && cfg_bad) cfg_err <= 1'b1;
      out_valid <= accept && hit;
      out_miss  <= accept && !hit;
      if (accept && hit) begin
        out_addr  <= w_tgt[sel] + (req_addr - w_base[sel]);
        out_asid  <= w_asid[sel];
        out_win   <= sel;
        out_write <= req_write;
      end
    end
  end
endmodule

// File: rtl/ingress_window_xlate_chk.sv
module ingress_window_xlate_chk #(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  parameter int CW   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_we,
  input logic                      cfg_en,
  input logic [AW-1:0]             cfg_len,
  input logic                      cfg_err,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      out_valid,
  input logic                      out_miss,
  input logic [NWIN-1:0][CW-1:0]   cnt
);
  // R4
  out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, out_miss}));

  // R3
  out_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_miss) |-> $past(req_valid && req_ready));

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_en && cfg_len == '0) |=> cfg_err);

  // R9
  stall_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (|cnt));

  genvar gi;
  generate
    for (gi = 0; gi < NWIN; gi++) begin : g_c
      // R9
      count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[gi] != $past(cnt[gi])) |->
          (cnt[gi] == $past(cnt[gi]) + 1'b1 || cnt[gi] == $past(cnt[gi]) - 1'b1));
    end
  endgenerate
endmodule

bind ingress_window_xlate ingress_window_xlate_chk #(.NWIN(NWIN), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_len(cfg_len),
  .cfg_err(cfg_err), .req_valid(req_valid), .req_ready(req_ready),
  .out_valid(out_valid), .out_miss(out_miss), .cnt(cnt)
);

// File: tb/test_ingress_window_xlate.sv
module test_ingress_window_xlate;
  localparam int CLK = 10;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, cfg_en = 0;
  logic [2:0]  cfg_idx = 0;
  logic [1:0]  cfg_mac = 0, cfg_order = 0;
  logic [31:0] cfg_base = 0, cfg_len = 0, cfg_tgt = 0;
  logic [3:0]  cfg_asid = 0;
  logic        cfg_err;
  logic        req_valid = 0, req_ready, req_write = 0, req_relaxed = 0;
  logic [31:0] req_addr = 0;
  logic [1:0]  req_mac = 0;
  logic        wc_valid = 0;
  logic [2:0]  wc_win = 0;
  logic        out_valid, out_miss, out_write;
  logic [31:0] out_addr;
  logic [3:0]  out_asid;
  logic [2:0]  out_win;

  int checks = 0, errors = 0;

  logic        m_en  [8];
  logic [1:0]  m_mac [8];
  logic [31:0] m_base[8], m_len[8], m_tgt[8];
  logic [3:0]  m_asid[8];

  ingress_window_xlate i_ingress_window_xlate (.*);

  always #(CLK/2) clk = ~clk;

  initial begin
    #(CLK * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int lookup(input logic [31:0] a, input logic [1:0] mac);
    for (int i = 0; i < 8; i++)
      if (m_en[i] && m_mac[i] == mac && a >= m_base[i] && (a - m_base[i]) < m_len[i])
        return i;
    return -1;
  endfunction

  task automatic cfg(input int idx, input logic en, input logic [1:0] mac,
                     input logic [31:0] base, len, tgt,
                     input logic [1:0] ord, input logic [3:0] asid);
    logic bad;
    bad = en && ((base[11:0] != 0) || (len[11:0] != 0) || len == 0);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx[2:0]; cfg_en = en; cfg_mac = mac; cfg_base = base;
    cfg_len = len; cfg_tgt = tgt; cfg_order = ord; cfg_asid = asid;
    @(negedge clk);
    cfg_we = 0;
    if (!bad) begin
      m_en[idx] = en; m_mac[idx] = mac; m_base[idx] = base;
      m_len[idx] = len; m_tgt[idx] = tgt; m_asid[idx] = asid;
    end
  endtask

  task automatic wc(input int win);
    @(negedge clk);
    wc_valid = 1; wc_win = win[2:0];
    @(negedge clk);
    wc_valid = 0;
  endtask

  // Drive one request; check ready; if accepted, check the registered outputs.
  task automatic req(input string tag, input logic [31:0] a, input logic wr,
                     input logic rel, input logic [1:0] mac, input logic exp_rdy);
    int w;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = wr; req_relaxed = rel; req_mac = mac;
    #1;
    check({tag, " ready"}, req_ready, exp_rdy);
    @(negedge clk);
    req_valid = 0;
    w = lookup(a, mac);
    if (!exp_rdy) begin
      check({tag, " held no out"}, {out_valid, out_miss}, 2'b00);
    end else if (w < 0) begin
      check({tag, " miss"}, {out_valid, out_miss}, 2'b01);
    end else begin
      check({tag, " hit"}, {out_valid, out_miss}, 2'b10);
      check({tag, " addr"}, out_addr, m_tgt[w] + (a - m_base[w]));
      check({tag, " asid/win/wr"}, {out_asid, out_win, out_write},
            {m_asid[w], w[2:0], wr});
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_en[i] = 0; m_mac[i] = 0; m_base[i] = 0; m_len[i] = 0; m_tgt[i] = 0; m_asid[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {cfg_err, out_valid, out_miss, req_ready}, 4'b0001);
    rst_n = 1;
    req("R1 empty table miss", 32'h1000, 1'b0, 1'b0, 2'd0, 1'b1);

    cfg(0, 1, 2'd0, 32'h1000, 32'h2000, 32'h8000_0000, 2'd0, 4'd1);
    cfg(1, 1, 2'd0, 32'h2000, 32'h4000, 32'h9000_0000, 2'd1, 4'd2);
    cfg(2, 1, 2'd1, 32'h2000, 32'h1000, 32'hA000_0000, 2'd2, 4'd3);
    cfg(3, 0, 2'd0, 32'h0000, 32'h1000, 32'hB000_0000, 2'd0, 4'd4);
    // R2 R3 R4 R10 sweep of window edges, overlap and MAC binding
    for (int m = 0; m < 3; m++)
      for (int a = 0; a < 60; a++)
        for (int k = 0; k < 2; k++)
          req("R2 R3 R4 R10 sweep", a * 32'h200 + (k ? 32'h1FF : 32'h0), 1'b0, 1'b0,
              m[1:0], 1'b1);

    // R5 refused writes leave window 0 intact
    check("R5 err before", cfg_err, 1'b0);
    cfg(0, 1, 2'd0, 32'h5000_0800, 32'h1000, 32'h0, 2'd0, 4'd9);
    check("R5 misaligned base", cfg_err, 1'b1);
    cfg(0, 1, 2'd0, 32'h5000_0000, 32'h0, 32'h0, 2'd0, 4'd9);
    cfg(0, 1, 2'd0, 32'h5000_0000, 32'h1100, 32'h0, 2'd0, 4'd9);
    check("R5 sticky", cfg_err, 1'b1);
    req("R5 window unchanged", 32'h1234, 1'b0, 1'b0, 2'd0, 1'b1);

    // R10 disable window 0; overlap now goes to window 1
    cfg(0, 0, 2'd0, 32'h0, 32'h0, 32'h0, 2'd0, 4'd0);
    req("R10 disabled falls through", 32'h2010, 1'b0, 1'b0, 2'd0, 1'b1);
    req("R10 disabled miss", 32'h1010, 1'b0, 1'b0, 2'd0, 1'b1);

    cfg(4, 1, 2'd3, 32'h10000, 32'h1000, 32'hC000_0000, 2'd1, 4'd5);
    cfg(5, 1, 2'd3, 32'h20000, 32'h1000, 32'hD000_0000, 2'd2, 4'd6);
    cfg(6, 1, 2'd3, 32'h30000, 32'h1000, 32'hE000_0000, 2'd0, 4'd7);
    cfg(7, 1, 2'd3, 32'h40000, 32'h1000, 32'hF000_0000, 2'd3, 4'd8);

    // R6 unordered
    req("R6 write", 32'h30010, 1'b1, 1'b0, 2'd3, 1'b1);
    req("R6 write again", 32'h30020, 1'b1, 1'b0, 2'd3, 1'b1);
    req("R6 read held", 32'h30030, 1'b0, 1'b0, 2'd3, 1'b0);
    wc(6);
    req("R6 read held one left", 32'h30030, 1'b0, 1'b0, 2'd3, 1'b0);
    wc(6);
    req("R6 read released", 32'h30030, 1'b0, 1'b0, 2'd3, 1'b1);

    // R7 strict
    req("R7 write", 32'h10000, 1'b1, 1'b0, 2'd3, 1'b1);
    req("R7 write held", 32'h10008, 1'b1, 1'b1, 2'd3, 1'b0);
    req("R7 read held", 32'h10008, 1'b0, 1'b0, 2'd3, 1'b0);
    wc(4);
    req("R7 write after drain", 32'h10FFF, 1'b1, 1'b0, 2'd3, 1'b1);
    wc(4);
    req("R7 code3 write", 32'h40000, 1'b1, 1'b0, 2'd3, 1'b1);
    req("R7 code3 relaxed write held", 32'h40004, 1'b1, 1'b1, 2'd3, 1'b0);
    wc(7);

    // R8 obey-packet
    req("R8 write", 32'h20000, 1'b1, 1'b0, 2'd3, 1'b1);
    req("R8 ordered write held", 32'h20004, 1'b1, 1'b0, 2'd3, 1'b0);
    req("R8 relaxed write passes", 32'h20008, 1'b1, 1'b1, 2'd3, 1'b1);
    req("R8 read held", 32'h2000C, 1'b0, 1'b1, 2'd3, 1'b0);
    wc(5); wc(5);
    req("R8 read released", 32'h2000C, 1'b0, 1'b0, 2'd3, 1'b1);

    // R9 completion at zero ignored
    wc(6);
    req("R9 write after stray completion", 32'h30000, 1'b1, 1'b0, 2'd3, 1'b1);
    req("R9 read held count one", 32'h30000, 1'b0, 1'b0, 2'd3, 1'b0);
    wc(6);
    req("R9 read after drain", 32'h30000, 1'b0, 1'b0, 2'd3, 1'b1);
    // R9 saturation at 15
    for (int i = 0; i < 15; i++)
      req("R9 fill", 32'h30000 + i * 4, 1'b1, 1'b1, 2'd3, 1'b1);
    req("R9 write held at max", 32'h30100, 1'b1, 1'b1, 2'd3, 1'b0);
    wc(6);
    req("R9 write after one completion", 32'h30100, 1'b1, 1'b1, 2'd3, 1'b1);
    for (int i = 0; i < 15; i++) wc(6);
    req("R9 read after full drain", 32'h30100, 1'b0, 1'b0, 2'd3, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule